// File: doc/BRIEF.md
# Address-Folded SECDED Memory with Background Scrubber

This block holds a small synchronous memory in which every word is protected by an extended Hamming code. The code can correct any single flipped bit and detect any two flipped bits. The check bits are computed over the data word together with its logical address. The address itself is never stored. On every read the code is recomputed with the requested address. A decoder fault that lands on the wrong row therefore produces a nonzero syndrome and is reported as an error; it is never returned as good data.

Software sees the following:
- Each host read returns a corrected or uncorrectable flag.
- A saturating count of all corrections is kept, and software can clear it.
- A limit flag rises once the count reaches a programmable threshold.

Whenever the host port is idle, a scrubber visits one word per cycle. If the word has a single-bit error, the scrubber writes the repaired word back, so that separate upsets do not pile up into a double error. Two test inputs support fault campaigns. One XORs a mask into a stored word. The other perturbs the row address that the host port decodes.

Top module: `ecc_scrub_mem`

## Requirements
- R1: After reset every word holds data zero with valid code bits, so a read of any address returns zero with both flags low. The correction count is zero, `rdValid` is low and the scrub pointer is at address 0.
- R2: A host read (`req`=1, `we`=0) sets `rdValid` in the next cycle. In that cycle `rdata` holds the word last written to that address, and both flags are low when the word is intact.
- R3: With the default parameters a stored word is 22 bits laid out as data [15:0], check bits [20:16] and overall parity [21]. A single flipped bit anywhere in it is corrected on read: `rdata` is the written data and `corrected`=1. The read does not repair the stored word.
- R4: Two flipped bits give `uncorrectable`=1 and `corrected`=0, with the raw, uncorrected data bits on `rdata`. Such a read leaves the correction count unchanged.
- R5: A nonzero `decFault` XORs the row used by host reads and writes, while the code is still checked against `addr`. Reading an intact word through a 1-bit or 2-bit decoder fault gives `uncorrectable`=1 with that row's raw data. This holds even when the syndrome points at an address bit.
- R6: Each correction adds one to `corrCount`, whether it comes from a host read or from a scrub write-back. The count saturates at 2^CNT_W-1 (15 with the defaults).
- R7: `clrCount` zeroes `corrCount` at the next edge and takes priority over an increment in the same cycle.
- R8: `limitHit` is high exactly when `corrCount` >= `corrLimit`.
- R9: A cycle with `req`=0 and `injValid`=0 is idle. In each idle cycle the scrubber checks the word at its pointer and then moves the pointer by one, wrapping at the top of memory. A word with a single error is rewritten in corrected form. A word with two errors is left unchanged.
- R10: `injValid` XORs `injMask` into the stored word at `injAddr`. A host write to the same physical row in the same cycle wins. `decFault` has no effect on the scrubber or on injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host access request |
| we | input | 1 | Host write (1) or read (0) |
| addr | input | ADDR_W | Host logical address |
| wdata | input | DATA_W | Host write data |
| decFault | input | ADDR_W | Test: XOR applied to the host row decode |
| injValid | input | 1 | Test: apply bit-flip injection this cycle |
| injAddr | input | ADDR_W | Test: injection row |
| injMask | input | DATA_W+check+1 | Test: stored-word bits to flip |
| clrCount | input | 1 | Clear correction count |
| corrLimit | input | CNT_W | Correction count threshold |
| rdValid | output | 1 | Read result valid |
| rdata | output | DATA_W | Read data |
| corrected | output | 1 | Read needed a single-bit correction |
| uncorrectable | output | 1 | Read found an uncorrectable error |
| corrCount | output | CNT_W | Saturating correction count |
| limitHit | output | 1 | Count has reached the threshold |

## Verification
The scrubber's write-back is the hardest behaviour to reach from the ports, because it only runs in idle cycles and its only visible trace is a later read or a count step. The bench keeps the host port busy with filler reads of a reserved, never-corrupted address, so that idle cycles happen only when it chooses. It also tracks the scrub pointer itself. After an idle burst it checks the count, and it re-reads words that held single and double flips to confirm which were rewritten. Address faults are applied only to intact rows, with 1-bit and 2-bit masks, so that the aliasing case, where the syndrome points at an address bit, is covered.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic hostWr;
    logic hostRd;
    logic scrubWb;
    logic inject;
  } memStrobe_t;

  // Smallest Hamming check width p with 2^p >= msgW + p + 1.
  function automatic int chkWidth(int msgW);
    int p;
    p = 1;
    for (int k = 0; k < 16; k++)
      if ((1 << p) < msgW + p + 1) p = p + 1;
    return p;
  endfunction

  // Stored word: data, check bits, overall parity.
  function automatic int storeWidth(int dataW, int addrW);
    return dataW + chkWidth(dataW + addrW) + 1;
  endfunction

endpackage

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_scrub_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              injValid,
  input  logic              clrCount,
  input  logic [CNT_W-1:0]  corrLimit,
  input  logic              curSingle,
  input  logic              curUncorr,
  output memStrobe_t        strb,
  output logic [ADDR_W-1:0] scrubAddr,
  output logic [CNT_W-1:0]  corrCount,
  output logic              limitHit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic idle;
  logic bump;
  logic [ADDR_W-1:0] scrubPtr;

  assign idle = !req && !injValid;

  always_comb begin
    strb.hostWr  = req && we;
    strb.hostRd  = req && !we;
    strb.scrubWb = idle && curSingle;
    strb.inject  = injValid;
  end

  // A correction is counted on host reads and on scrub visits.
  assign bump = (strb.hostRd || idle) && curSingle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corrCount <= '0;
      scrubPtr  <= '0;
    end else begin
      if (clrCount)
        corrCount <= '0;
      else if (bump && corrCount != CNT_MAX)
        corrCount <= corrCount + 1'b1;
      if (idle)
        scrubPtr <= scrubPtr + 1'b1;
    end
  end

  assign scrubAddr = scrubPtr;
  assign limitHit  = corrCount >= corrLimit;

  a_r6_saturate : assert property (@(posedge clk) disable iff (!rst_n)
    (corrCount == CNT_MAX && !clrCount) |=> corrCount == CNT_MAX);

  a_r7_clear_wins : assert property (@(posedge clk) disable iff (!rst_n)
    clrCount |=> corrCount == '0);

  a_r6_single_step : assert property (@(posedge clk) disable iff (!rst_n)
    !clrCount |=> (corrCount == $past(corrCount) ||
                   corrCount == $past(corrCount) + 1'b1));

  a_r4_no_count : assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && curUncorr && !clrCount) |=> $stable(corrCount));

endmodule

// File: rtl/ecc_scrub_dpath.sv
module ecc_scrub_dpath
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  memStrobe_t                                  strb,
  input  logic [ADDR_W-1:0]                           hostAddr,
  input  logic [DATA_W-1:0]                           hostWdata,
  input  logic [ADDR_W-1:0]                           decFault,
  input  logic [ADDR_W-1:0]                           scrubAddr,
  input  logic [ADDR_W-1:0]                           injAddr,
  input  logic [storeWidth(DATA_W, ADDR_W)-1:0]       injMask,
  output logic                                        curSingle,
  output logic                                        curUncorr,
  output logic                                        rdValid,
  output logic [DATA_W-1:0]                           rdata,
  output logic                                        corrected,
  output logic                                        uncorrectable
);

  localparam int MSG_W   = DATA_W + ADDR_W;
  localparam int CHK_W   = chkWidth(MSG_W);
  localparam int STORE_W = DATA_W + CHK_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;

  // Codeword position of message bit idx (skips power-of-two slots).
  function automatic int msgPos(int idx);
    int pos;
    int cnt;
    pos = 0;
    cnt = -1;
    for (int q = 3; q < 256; q++)
      if (cnt < idx && (q & (q - 1)) != 0) begin
        cnt = cnt + 1;
        pos = q;
      end
    return pos;
  endfunction

  function automatic logic [CHK_W-1:0] calcChk(logic [MSG_W-1:0] msg);
    logic [CHK_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < MSG_W; i++)
      if (msg[i]) acc = acc ^ CHK_W'(msgPos(i));
    return acc;
  endfunction

  function automatic logic [STORE_W-1:0] encode(logic [ADDR_W-1:0] a,
                                                logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = calcChk({a, d});
    return {^{a, d, c}, c, d};
  endfunction

  logic [STORE_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0]  logAddr;
  logic [ADDR_W-1:0]  physAddr;
  logic [STORE_W-1:0] curWord;
  logic [DATA_W-1:0]  stData;
  logic [CHK_W-1:0]   stChk;
  logic               stPar;
  logic [CHK_W-1:0]   syn;
  logic               parOdd;
  logic [DATA_W-1:0]  flip;
  logic [DATA_W-1:0]  fixData;

  // Host reads use the faulted row decode; the scrubber uses its own pointer.
  assign logAddr  = strb.hostRd ? hostAddr : scrubAddr;
  assign physAddr = strb.hostRd ? (hostAddr ^ decFault) : scrubAddr;

  always_comb begin
    curWord = mem[physAddr];
    stData  = curWord[DATA_W-1:0];
    stChk   = curWord[DATA_W +: CHK_W];
    stPar   = curWord[STORE_W-1];
    syn     = stChk ^ calcChk({logAddr, stData});
    parOdd  = stPar ^ (^{logAddr, stData, stChk});
    flip    = '0;
    for (int i = 0; i < DATA_W; i++)
      if (syn == CHK_W'(msgPos(i))) flip[i] = 1'b1;
    // Odd parity and a syndrome naming a data bit, a check bit or nothing
    // (parity bit) is correctable; an address-bit syndrome is not.
    curSingle = parOdd && (syn == '0 || $onehot(syn) || (|flip));
    curUncorr = (syn != '0 || parOdd) && !curSingle;
    fixData   = stData ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= encode(ADDR_W'(i), '0);
    end else begin
      if (strb.inject)
        mem[injAddr] <= mem[injAddr] ^ injMask;
      if (strb.scrubWb)
        mem[scrubAddr] <= encode(scrubAddr, fixData);
      if (strb.hostWr)
        mem[hostAddr ^ decFault] <= encode(hostAddr, hostWdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid       <= 1'b0;
      rdata         <= '0;
      corrected     <= 1'b0;
      uncorrectable <= 1'b0;
    end else begin
      rdValid       <= strb.hostRd;
      corrected     <= strb.hostRd && curSingle;
      uncorrectable <= strb.hostRd && curUncorr;
      if (strb.hostRd)
        rdata <= curUncorr ? stData : fixData;
    end
  end

  a_r2_read_valid : assert property (@(posedge clk) disable iff (!rst_n)
    strb.hostRd |=> rdValid);

  a_r3_flags_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(corrected && uncorrectable));

endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req,
  input  logic                                  we,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wdata,
  input  logic [ADDR_W-1:0]                     decFault,
  input  logic                                  injValid,
  input  logic [ADDR_W-1:0]                     injAddr,
  input  logic [storeWidth(DATA_W, ADDR_W)-1:0] injMask,
  input  logic                                  clrCount,
  input  logic [CNT_W-1:0]                      corrLimit,
  output logic                                  rdValid,
  output logic [DATA_W-1:0]                     rdata,
  output logic                                  corrected,
  output logic                                  uncorrectable,
  output logic [CNT_W-1:0]                      corrCount,
  output logic                                  limitHit
);

  memStrobe_t        strb;
  logic [ADDR_W-1:0] scrubAddr;
  logic              curSingle;
  logic              curUncorr;

  ecc_scrub_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .injValid  (injValid),
    .clrCount  (clrCount),
    .corrLimit (corrLimit),
    .curSingle (curSingle),
    .curUncorr (curUncorr),
    .strb      (strb),
    .scrubAddr (scrubAddr),
    .corrCount (corrCount),
    .limitHit  (limitHit)
  );

  ecc_scrub_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .hostAddr      (addr),
    .hostWdata     (wdata),
    .decFault      (decFault),
    .scrubAddr     (scrubAddr),
    .injAddr       (injAddr),
    .injMask       (injMask),
    .curSingle     (curSingle),
    .curUncorr     (curUncorr),
    .rdValid       (rdValid),
    .rdata         (rdata),
    .corrected     (corrected),
    .uncorrectable (uncorrectable)
  );

endmodule

// File: tb/ecc_scrub_mem_tb_top.sv
`timescale 1ns/1ps
module ecc_scrub_mem_tb_top;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int SW = 22;
  localparam int DEPTH = 16;
  localparam int FILL = 15;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req, we, injValid, clrCount;
  logic [AW-1:0] addr, decFault, injAddr;
  logic [DW-1:0] wdata;
  logic [SW-1:0] injMask;
  logic [CW-1:0] corrLimit;
  logic          rdValid, corrected, uncorrectable, limitHit;
  logic [DW-1:0] rdata;
  logic [CW-1:0] corrCount;

  ecc_scrub_mem dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .decFault(decFault), .injValid(injValid), .injAddr(injAddr),
    .injMask(injMask), .clrCount(clrCount), .corrLimit(corrLimit),
    .rdValid(rdValid), .rdata(rdata), .corrected(corrected),
    .uncorrectable(uncorrectable), .corrCount(corrCount), .limitHit(limitHit)
  );

  int nChk = 0;
  int nFail = 0;
  logic [DW-1:0] refData [DEPTH];
  logic [SW-1:0] refMask [DEPTH];
  int refCnt = 0;
  int refPtr = 0;

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic checkCount(string rq);
    check(rq, "corrCount", 32'(corrCount), 32'(refCnt));
    check("R8", "limitHit", 32'(limitHit), 32'(refCnt >= int'(corrLimit)));
  endtask

  task automatic setFill();
    req = 1'b1; we = 1'b0; addr = AW'(FILL); decFault = '0;
    injValid = 1'b0; clrCount = 1'b0; wdata = '0;
  endtask

  task automatic doWrite(int a, logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    refData[a] = d; refMask[a] = '0;
    setFill();
  endtask

  task automatic doInject(int a, logic [SW-1:0] m);
    @(negedge clk);
    injValid = 1'b1; injAddr = AW'(a); injMask = m;
    @(negedge clk);
    refMask[a] = refMask[a] ^ m;
    setFill();
  endtask

  task automatic doRead(int a, logic clr, string rq);
    int pc;
    logic [DW-1:0] expD;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a); clrCount = clr;
    @(negedge clk);
    pc = $countones(refMask[a]);
    if (clr) refCnt = 0;
    else if (pc == 1 && refCnt < CMAX) refCnt++;
    expD = (pc >= 2) ? (refData[a] ^ refMask[a][DW-1:0]) : refData[a];
    check(rq, "rdValid", 32'(rdValid), 32'd1);
    check(rq, "rdata", 32'(rdata), 32'(expD));
    check(rq, "corrected", 32'(corrected), 32'(pc == 1));
    check(rq, "uncorrectable", 32'(uncorrectable), 32'(pc >= 2));
    checkCount(clr ? "R7" : "R6");
    setFill();
  endtask

  task automatic doFaultRead(int a, logic [AW-1:0] f);
    int p;
    p = a ^ int'(f);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a); decFault = f;
    @(negedge clk);
    check("R5", "uncorrectable", 32'(uncorrectable), 32'd1);
    check("R5", "corrected", 32'(corrected), 32'd0);
    check("R5", "rdata", 32'(rdata), 32'(refData[p]));
    checkCount("R5");
    setFill();
  endtask

  task automatic doIdle(int n);
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ($countones(refMask[refPtr]) == 1) begin
        refMask[refPtr] = '0;
        if (refCnt < CMAX) refCnt++;
      end
      refPtr = (refPtr + 1) % DEPTH;
    end
    setFill();
    checkCount("R9");
  endtask

  task automatic doClear();
    @(negedge clk);
    clrCount = 1'b1;
    @(negedge clk);
    refCnt = 0;
    setFill();
    checkCount("R7");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin refData[i] = '0; refMask[i] = '0; end
    setFill();
    injAddr = '0; injMask = '0; corrLimit = 4'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "rdValid", 32'(rdValid), 32'd0);
    check("R1", "corrCount", 32'(corrCount), 32'd0);
    check("R1", "limitHit", 32'(limitHit), 32'd0);
    for (int a = 0; a < DEPTH; a++) doRead(a, 1'b0, "R1");

    // R2: plain write and read
    doWrite(2, 16'hA5C3);
    doWrite(7, 16'h0001);
    doRead(2, 1'b0, "R2");
    doRead(7, 1'b0, "R2");

    // R3: single flip in data, check and parity bits
    doWrite(4, 16'h1234);
    doInject(4, SW'(1) << 3);
    doRead(4, 1'b0, "R3");
    doWrite(5, 16'hFFFF);
    doInject(5, SW'(1) << 17);
    doRead(5, 1'b0, "R3");
    doWrite(6, 16'h8000);
    doInject(6, SW'(1) << 21);
    doRead(6, 1'b0, "R3");

    // R4: double flip, raw data, count unchanged
    doWrite(8, 16'h5A5A);
    doInject(8, (SW'(1) << 0) | (SW'(1) << 9));
    doRead(8, 1'b0, "R4");
    doWrite(9, 16'h0F0F);
    doInject(9, (SW'(1) << 2) | (SW'(1) << 18));
    doRead(9, 1'b0, "R4");

    // R5: decoder faults on intact rows
    doWrite(0, 16'hC0DE);
    doWrite(1, 16'hBEEF);
    doWrite(3, 16'h7777);
    doFaultRead(0, 4'b0001);
    doFaultRead(1, 4'b0010);
    doFaultRead(2, 4'b0011);

    // R9: scrub repairs singles, leaves doubles
    doIdle(DEPTH);
    doRead(4, 1'b0, "R9");
    doRead(8, 1'b0, "R9");
    doInject(10, SW'(1) << 12);
    doIdle(3);
    doIdle(DEPTH);
    doRead(10, 1'b0, "R9");

    // R7: clear, and clear racing a correction
    doClear();
    doInject(11, SW'(1) << 5);
    doRead(11, 1'b1, "R7");
    doRead(11, 1'b0, "R7");

    // R6 / R8: saturation and threshold
    corrLimit = 4'd12;
    for (int k = 0; k < 18; k++) doRead(11, 1'b0, "R6");
    corrLimit = 4'd15;
    doRead(11, 1'b0, "R8");
    doClear();

    // R10: injection loses to a host write to the same row
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(12); wdata = 16'h4321;
    injValid = 1'b1; injAddr = AW'(12); injMask = SW'(3);
    @(negedge clk);
    refData[12] = 16'h4321; refMask[12] = '0;
    setFill();
    doRead(12, 1'b0, "R10");

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      int a;
      op = int'($urandom % 10);
      a = int'($urandom % (DEPTH - 1));
      if (op < 2) doWrite(a, DW'($urandom));
      else if (op < 4) begin
        if ($countones(refMask[a]) < 2) begin
          int b;
          b = int'($urandom % SW);
          while (refMask[a][b]) b = int'($urandom % SW);
          doInject(a, SW'(1) << b);
        end
      end else if (op < 7) doRead(a, 1'b0, "R3");
      else if (op == 7) doIdle(1 + int'($urandom % 20));
      else if (op == 8) begin
        logic [AW-1:0] f;
        f = AW'(1) << ($urandom % AW);
        if ($urandom % 2 == 1) f = f | (AW'(1) << ($urandom % AW));
        if (refMask[a ^ int'(f)] == '0 && f != '0) doFaultRead(a, f);
      end else begin
        if ($urandom % 4 == 0) doClear();
        else corrLimit = CW'($urandom);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule